// File: doc/BRIEF.md
# Hysteretic PWM Timer Channel

This block is one timer channel that closes a hysteretic current loop entirely in logic. Two digital comparator outputs drive it. One comparator restarts the channel counter, so it sets the switching period. The other clears the output reference for the rest of the current cycle, so it ends the on-time. Between them they set both frequency and duty cycle, with no software in the loop.

The counter runs free up to a programmed period when neither comparator acts. This gives a minimum switching frequency. A compare value marks where the reference turns active in each cycle, which bounds the duty cycle. The reference drives a complementary pair of outputs, with programmable dead time before either output turns on. A break input parks both outputs at programmed idle levels at once. A one-shot force command lets switching start before any comparator event has occurred.

A clear that arrives early, followed by a counter restart before the compare point, releases the clear state at the restart. The reference therefore switches normally in the very next cycle and never loses a whole cycle.

Top module: `hyst_pwm_channel`

## Requirements
- R1: With no restart event, `count_o` counts 0, 1, …, `cfg_period` and then returns to 0, so one cycle lasts `cfg_period`+1 clocks.
- R2: A rising edge on `cmp_reset_in` sets `count_o` to 0 three clock edges after the input changes (two synchronizer stages plus edge detection). Holding the input high does not cause another restart.
- R3: With no clear or force, `ref_o` is 0 from the start of a cycle until `count_o` equals `cfg_compare`, and 1 from then until the cycle ends. If `cfg_compare` is 0, `ref_o` is 1 for the whole cycle. If `cfg_compare` is above `cfg_period`, `ref_o` stays 0.
- R4: A rising edge on `cmp_clear_in` forces `ref_o` to 0 three clock edges after the input changes. `ref_o` then stays 0 until the next cycle start, even if the input stays high. After that start the compare point works normally again.
- R5: Suppose a clear has latched and a restart from `cmp_reset_in` then arrives before the compare point. In the new cycle, `ref_o` still becomes 1 when `count_o` reaches `cfg_compare`.
- R6: A one-clock pulse on `cmd_force` sets `ref_o` to 1 on the next clock edge, when no clear is latched. The setting lasts only until the end of the current cycle, and the following cycle follows R3.
- R7: When enabled and not in break, `out_hi` follows `ref_o` and `out_lo` follows its inverse. Each output turns on `cfg_deadtime` clocks after the `ref_o` edge that calls for it, and turns off at once. With `cfg_deadtime` = 0 the outputs are exact copies of `ref_o` and its inverse.
- R8: While `brk_in` is 1, `out_hi` equals `cfg_idle_hi` and `out_lo` equals `cfg_idle_lo` in the same cycle (combinational path), overriding every other source.
- R9: Outputs show the idle levels from reset, and again after a break ends, until they are enabled. A `cmd_arm` pulse enables them from the next clock edge. With `cfg_auto_en` = 1 they re-enable on the first clock edge at which `brk_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CNT_W | Last count value of a free-running cycle |
| cfg_compare | input | CNT_W | Count at which the reference turns active |
| cfg_deadtime | input | DT_W | Turn-on delay in clocks for each output |
| cfg_idle_hi | input | 1 | Level of `out_hi` while parked |
| cfg_idle_lo | input | 1 | Level of `out_lo` while parked |
| cfg_auto_en | input | 1 | Re-enable outputs automatically after break |
| cmd_arm | input | 1 | One-clock pulse that enables the outputs |
| cmd_force | input | 1 | One-clock pulse that sets the reference active |
| cmp_reset_in | input | 1 | Comparator input that restarts the counter |
| cmp_clear_in | input | 1 | Comparator input that clears the reference |
| brk_in | input | 1 | Break: parks outputs at idle levels |
| ref_o | output | 1 | Output reference |
| count_o | output | CNT_W | Counter value |
| out_hi | output | 1 | High-side output |
| out_lo | output | 1 | Low-side output |

## Verification
The bench builds the channel with an 8-bit counter and a 4-bit dead-time field, and programs a period of 9. A full cycle is then ten clocks, so wraps, compare points, early clears and restarts before the compare point all fit within a few dozen clocks of each scenario. Compare values of 0, 4, 6 and 12 cover a reference active all cycle, a mid-cycle compare point, the clear-then-restart corner case and a compare point that is never reached. Dead times of 2 and 0 cover both the delayed turn-on and the plain complementary copy.

// File: rtl/hyst_pwm_channel.sv
module hyst_pwm_channel #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_compare,
  input  logic [DT_W-1:0]  cfg_deadtime,
  input  logic             cfg_idle_hi,
  input  logic             cfg_idle_lo,
  input  logic             cfg_auto_en,
  input  logic             cmd_arm,
  input  logic             cmd_force,
  input  logic             cmp_reset_in,
  input  logic             cmp_clear_in,
  input  logic             brk_in,
  output logic             ref_o,
  output logic [CNT_W-1:0] count_o,
  output logic             out_hi,
  output logic             out_lo
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [DT_W-1:0]  DT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};

  logic [2:0]       rs_sh, cl_sh;
  logic [CNT_W-1:0] cnt_q;
  logic             ref_q, ref_d, clr_q, oe_q;
  logic [DT_W-1:0]  dt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_sh <= '0;
      cl_sh <= '0;
    end else begin
      rs_sh <= {rs_sh[1:0], cmp_reset_in};
      cl_sh <= {cl_sh[1:0], cmp_clear_in};
    end
  end

  wire rst_evt   = rs_sh[1] & ~rs_sh[2];
  wire clr_evt   = cl_sh[1] & ~cl_sh[2];
  wire wrap      = cnt_q >= cfg_period;
  wire cyc_start = rst_evt | wrap;
  wire [CNT_W-1:0] cnt_inc = cnt_q + CNT_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cyc_start ? '0 : cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      clr_q <= 1'b0;
    end else if (cyc_start) begin
      ref_q <= (cfg_compare == '0);
      clr_q <= 1'b0;
    end else if (clr_evt) begin
      ref_q <= 1'b0;
      clr_q <= 1'b1;
    end else if (!clr_q && (cmd_force || cnt_inc == cfg_compare)) begin
      ref_q <= 1'b1;
    end
  end

  wire dt_nz  = cfg_deadtime != '0;
  wire chg    = ref_q ^ ref_d;
  wire busy   = (chg & dt_nz) | (dt_q != '0);
  wire hi_act = ref_q & ~busy;
  wire lo_act = ~ref_q & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      dt_q  <= '0;
    end else begin
      ref_d <= ref_q;
      if (chg)              dt_q <= dt_nz ? cfg_deadtime - DT_ONE : '0;
      else if (dt_q != '0)  dt_q <= dt_q - DT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       oe_q <= 1'b0;
    else if (brk_in)                  oe_q <= 1'b0;
    else if (cmd_arm || cfg_auto_en)  oe_q <= 1'b1;
  end

  wire park = brk_in | ~oe_q;
  assign out_hi  = park ? cfg_idle_hi : hi_act;
  assign out_lo  = park ? cfg_idle_lo : lo_act;
  assign ref_o   = ref_q;
  assign count_o = cnt_q;

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= cfg_period) |=> (cnt_q == '0));
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_sh[1] && !rs_sh[2]) |=> (cnt_q == '0));
  a_r4_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !cyc_start) |=> !ref_q);
  a_r5_rearm_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !clr_q);
  a_r7_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_nz && $rose(hi_act)) |-> $past(!lo_act));
  a_r9_break_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in |=> !oe_q);
endmodule

// File: tb/test_hyst_pwm_channel.sv
`timescale 1ns/1ps
module test_hyst_pwm_channel;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int PER = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_period = PER[CW-1:0];
  logic [CW-1:0] cfg_compare = 8'd4;
  logic [DW-1:0] cfg_deadtime = 4'd2;
  logic cfg_idle_hi = 1'b0, cfg_idle_lo = 1'b0, cfg_auto_en = 1'b0;
  logic cmd_arm = 1'b0, cmd_force = 1'b0;
  logic cmp_reset_in = 1'b0, cmp_clear_in = 1'b0, brk_in = 1'b0;
  logic ref_o, out_hi, out_lo;
  logic [CW-1:0] count_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hyst_pwm_channel #(.CNT_W(CW), .DT_W(DW)) i_hyst_pwm_channel (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_compare(cfg_compare),
    .cfg_deadtime(cfg_deadtime), .cfg_idle_hi(cfg_idle_hi), .cfg_idle_lo(cfg_idle_lo),
    .cfg_auto_en(cfg_auto_en), .cmd_arm(cmd_arm), .cmd_force(cmd_force),
    .cmp_reset_in(cmp_reset_in), .cmp_clear_in(cmp_clear_in), .brk_in(brk_in),
    .ref_o(ref_o), .count_o(count_o), .out_hi(out_hi), .out_lo(out_lo));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cnt(input int v);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (count_o != v[CW-1:0] && k < 300);
    chk("R1 reach count", count_o, v);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset count", count_o, 0);
    chk("R3 reset ref", ref_o, 0);
    chk("R9 reset hi idle", out_hi, 0);
    chk("R9 reset lo idle", out_lo, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 unarmed hi idle", out_hi, 0);
      chk("R9 unarmed lo idle", out_lo, 0);
    end
  endtask

  task automatic t_pwm(input int cmpv);
    cfg_compare = cmpv[CW-1:0];
    wait_cnt(PER);
    wait_cnt(PER);
    for (int i = 0; i < 2 * (PER + 1); i++) begin
      @(negedge clk);
      chk("R1 count sequence", count_o, i % (PER + 1));
      chk("R3 pwm2 ref", ref_o, (i % (PER + 1)) >= cmpv ? 1 : 0);
    end
  endtask

  task automatic t_outputs(input int dt);
    cfg_compare = 8'd4;
    cfg_deadtime = dt[DW-1:0];
    cmd_arm = 1'b1;
    @(negedge clk);
    cmd_arm = 1'b0;
    wait_cnt(PER);
    wait_cnt(PER);
    for (int i = 0; i <= PER; i++) begin
      @(negedge clk);
      chk("R7 out_hi", out_hi, (i >= 4 + dt) ? 1 : 0);
      chk("R7 out_lo", out_lo, (i >= dt && i < 4) ? 1 : 0);
    end
  endtask

  task automatic t_restart();
    wait_cnt(3);
    cmp_reset_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not yet restarted", count_o, 5);
    @(negedge clk);
    chk("R2 restart at zero", count_o, 0);
    repeat (5) @(negedge clk);
    chk("R2 held level no retrigger", count_o, 5);
    cmp_reset_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_clear();
    cfg_compare = 8'd4;
    wait_cnt(5);
    cmp_clear_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R4 ref before clear acts", ref_o, 1);
    @(negedge clk);
    chk("R4 count at clear", count_o, 8);
    chk("R4 ref cleared", ref_o, 0);
    @(negedge clk);
    chk("R4 ref stays cleared", ref_o, 0);
    cmp_clear_in = 1'b0;
    @(negedge clk);
    chk("R4 new cycle ref", ref_o, 0);
    wait_cnt(4);
    chk("R4 compare works again", ref_o, 1);
  endtask

  task automatic t_corner();
    cfg_compare = 8'd6;
    wait_cnt(1);
    cmp_clear_in = 1'b1;
    @(negedge clk);
    cmp_reset_in = 1'b1;
    @(negedge clk);
    cmp_clear_in = 1'b0;
    @(negedge clk);
    cmp_reset_in = 1'b0;
    @(negedge clk);
    chk("R5 early restart count", count_o, 0);
    wait_cnt(5);
    chk("R5 ref before compare", ref_o, 0);
    @(negedge clk);
    chk("R5 count at compare", count_o, 6);
    chk("R5 ref active after clear+restart", ref_o, 1);
  endtask

  task automatic t_force();
    cfg_compare = 8'd12;
    wait_cnt(2);
    chk("R6 ref before force", ref_o, 0);
    cmd_force = 1'b1;
    @(negedge clk);
    cmd_force = 1'b0;
    chk("R6 forced active", ref_o, 1);
    wait_cnt(PER);
    chk("R6 held to cycle end", ref_o, 1);
    @(negedge clk);
    chk("R6 released at start", ref_o, 0);
    wait_cnt(5);
    chk("R6 not sticky", ref_o, 0);
  endtask

  task automatic t_break();
    cfg_compare = 8'd4;
    cfg_deadtime = 4'd0;
    cfg_idle_hi = 1'b1;
    cfg_idle_lo = 1'b1;
    wait_cnt(1);
    chk("R7 dt0 lo on", out_lo, 1);
    brk_in = 1'b1;
    #1;
    chk("R8 immediate hi", out_hi, 1);
    chk("R8 immediate lo", out_lo, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R8 parked hi", out_hi, 1);
      chk("R8 parked lo", out_lo, 1);
    end
    brk_in = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 stays parked hi", out_hi, 1);
      chk("R9 stays parked lo", out_lo, 1);
    end
    cmd_arm = 1'b1;
    @(negedge clk);
    cmd_arm = 1'b0;
    for (int i = 0; i < 12; i++) begin
      chk("R9 armed hi follows ref", out_hi, ref_o);
      chk("R9 armed lo follows ref", out_lo, !ref_o);
      @(negedge clk);
    end
    cfg_auto_en = 1'b1;
    brk_in = 1'b1;
    #1;
    chk("R8 auto break hi", out_hi, 1);
    repeat (3) @(negedge clk);
    brk_in = 1'b0;
    #1;
    chk("R9 parked until edge", out_hi & out_lo, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R9 auto hi follows ref", out_hi, ref_o);
      chk("R9 auto lo follows ref", out_lo, !ref_o);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_pwm(4);
    t_pwm(0);
    t_pwm(12);
    t_outputs(2);
    t_outputs(0);
    t_restart();
    t_clear();
    t_corner();
    t_force();
    t_break();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule